// File: doc/BRIEF.md
# Serial Converter Register Access Master

This block lets a host read and write the internal registers of up to four delta-sigma converters. The converters share one serial clock line and one serial data-in line, and each one has its own data-out line. The host gives one request: direction, byte count from one to four, a 4-bit register address and up to 32 bits of write data. The block then sends a packed instruction byte. After it, the block either shifts the data bytes out on the shared line or clocks them in from the converters. Bit timing comes from the system clock through a programmable phase length.

Read data is gathered into one 32-bit word per channel. Capture comes either from all four data-out lines at once or from a single selected line. A mode input decides who owns the serial pins. In halt/init mode the block owns them. In any other mode an external run-time sequencer drives them, and register traffic is refused.

Top module: `adc_sreg_master`

## Requirements
- R1: The instruction byte sent first is {dir, cnt[1:0], 0, addr[3:0]}. dir is 1 for a read and 0 for a write. cnt is the byte count minus one. The address sits in bits 3:0, and bit 4 is zero. The usual addresses are 0x0 data, 0x4 command, 0x8 offset trim and 0xC gain trim.
- R2: Every byte is sent most significant bit first. A write of N bytes sends wr_data[8N-1:0] most significant byte first, right after the instruction, for 8*(N+1) serial clock periods in total.
- R3: Each serial bit is a high phase of P system clocks followed by a low phase of P system clocks. P = max(clk_div, 2), latched when the request is accepted. sdi is set when sclk rises and does not change while sclk falls or stays low.
- R4: On a read, the data-out level is sampled on the last system clock of each high phase. The N bytes land right-aligned in the 32-bit word, and the unfilled upper bytes read as zero.
- R5: Channel k's word sits at rd_data[32k+31:32k]. With cap_all=1 all four lanes capture. With cap_all=0 only lane cap_sel captures, and the other words read zero after the read.
- R6: start is accepted only when the block is idle and halt_mode=1. A start while busy has no effect on the transfer in progress.
- R7: A start while idle with halt_mode=0 starts nothing. It raises mode_err for exactly one cycle, and busy stays low.
- R8: done is a one-cycle pulse, high in the cycle after edge 2*P*8*(N+1) counted from the accepting edge. rd_data is valid at done and holds until the next accepted read, and writes leave it unchanged.
- R9: With halt_mode=1 and no transfer in progress, sclk and sdi are low, including after reset. After reset rd_data is zero.
- R10: With halt_mode=0, sclk and sdi follow seq_sclk and seq_sdi in the same cycle. Dropping halt_mode during a transfer aborts it with no done pulse.
- R11: During the data bytes of a read, sdi is held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe |
| rd_nwr | input | 1 | 1 read, 0 write |
| nbytes_m1 | input | 2 | Byte count minus one |
| reg_addr | input | 4 | Converter register address |
| wr_data | input | 32 | Write data, right-aligned |
| cap_all | input | 1 | Capture all four lanes on reads |
| cap_sel | input | 2 | Lane captured when cap_all is 0 |
| halt_mode | input | 1 | 1 gives the pins to this block |
| clk_div | input | DIV_W | System clocks per serial clock phase |
| seq_sclk | input | 1 | Sequencer serial clock |
| seq_sdi | input | 1 | Sequencer serial data |
| sdo | input | 4 | Data-out line of each converter |
| sclk | output | 1 | Shared serial clock |
| sdi | output | 1 | Shared serial data to all converters |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| mode_err | output | 1 | One-cycle pulse for a refused request |
| rd_data | output | 128 | Four 32-bit read words |

## Verification
A transfer of N bytes with phase length P finishes in the cycle after edge 2*P*8*(N+1) counted from the accepting edge. The bench counts edges from acceptance to the first sampled done and compares the count with that formula, then checks that done is low one edge later. mode_err is due one edge after the refused start and is checked at the next falling clock edge. The pin mux is combinational, so it is checked in the same cycle as the stimulus. The converter model changes its data-out bit at the falling clock edge just after sclk rises, so the value is stable at least one full system clock before the design samples it at the end of the high phase.

// File: rtl/adc_sreg_pkg.sv
package adc_sreg_pkg;

    localparam int REG_W     = 32;
    localparam int NUM_CH    = 4;
    localparam int BYTE_W    = 8;
    localparam int MAX_BYTES = REG_W / BYTE_W;
    localparam int FRAME_W   = REG_W + BYTE_W;
    localparam int BIT_CNT_W = $clog2(FRAME_W + 1);
    localparam int SEL_W     = $clog2(NUM_CH);

    localparam logic [3:0] REG_DATA = 4'h0;
    localparam logic [3:0] REG_CMD  = 4'h4;
    localparam logic [3:0] REG_OFFS = 4'h8;
    localparam logic [3:0] REG_GAIN = 4'hC;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_HIGH,
        PH_LOW
    } phase_e;

    typedef struct packed {
        logic       rd;
        logic [1:0] nb_m1;
        logic [3:0] addr;
    } req_t;

    typedef struct packed {
        logic             all;
        logic [SEL_W-1:0] sel;
    } cap_t;

    function automatic logic [BYTE_W-1:0] pack_instr(req_t r);
        return {r.rd, r.nb_m1, 1'b0, r.addr};
    endfunction

    // Instruction then data, left-aligned so the frame shifts out from its top bit.
    function automatic logic [FRAME_W-1:0] build_frame(req_t r, logic [REG_W-1:0] d);
        logic [REG_W-1:0] aligned;
        aligned = d << (BYTE_W * (MAX_BYTES - 1 - int'(r.nb_m1)));
        if (r.rd) aligned = '0;
        return {pack_instr(r), aligned};
    endfunction

    function automatic logic [BIT_CNT_W-1:0] frame_bits(req_t r);
        return BIT_CNT_W'(BYTE_W * (int'(r.nb_m1) + 2));
    endfunction

endpackage

// File: rtl/adc_phase_timer.sv
module adc_phase_timer #(
    parameter int DIV_W     = 8,
    parameter int MIN_PHASE = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [DIV_W-1:0] div_in,
    input  logic             run,
    output logic             phase_end
);
    localparam logic [DIV_W-1:0] FLOOR = DIV_W'(MIN_PHASE);

    logic [DIV_W-1:0] per_q;
    logic [DIV_W-1:0] cnt_q;

    assign phase_end = run && (cnt_q == per_q - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            per_q <= FLOOR;
            cnt_q <= '0;
        end else if (load) begin
            per_q <= (div_in < FLOOR) ? FLOOR : div_in;
            cnt_q <= '0;
        end else if (run && !phase_end) begin
            cnt_q <= cnt_q + 1'b1;
        end else begin
            cnt_q <= '0;
        end
    end

endmodule

// File: rtl/adc_shift_ctrl.sv
module adc_shift_ctrl
    import adc_sreg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             accept,
    input  req_t             req_in,
    input  logic [REG_W-1:0] wr_data,
    input  logic             halt_mode,
    input  logic             phase_end,
    output logic             busy,
    output logic             sclk_o,
    output logic             sdi_o,
    output logic             sample_en,
    output logic             done
);
    phase_e               st_q;
    logic [FRAME_W-1:0]   frame_q;
    logic [BIT_CNT_W-1:0] bit_q;
    logic [BIT_CNT_W-1:0] total_q;
    logic                 rd_q;
    logic                 done_q;

    assign busy      = (st_q != PH_IDLE);
    assign sclk_o    = (st_q == PH_HIGH);
    assign sdi_o     = busy && frame_q[FRAME_W-1];
    assign done      = done_q;
    assign sample_en = (st_q == PH_HIGH) && phase_end && halt_mode && rd_q
                       && (bit_q >= BIT_CNT_W'(BYTE_W));

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= PH_IDLE;
            frame_q <= '0;
            bit_q   <= '0;
            total_q <= '0;
            rd_q    <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (st_q)
                PH_IDLE: begin
                    if (accept) begin
                        st_q    <= PH_HIGH;
                        frame_q <= build_frame(req_in, wr_data);
                        bit_q   <= '0;
                        total_q <= frame_bits(req_in);
                        rd_q    <= req_in.rd;
                    end
                end
                PH_HIGH: begin
                    if (!halt_mode)     st_q <= PH_IDLE;
                    else if (phase_end) st_q <= PH_LOW;
                end
                PH_LOW: begin
                    if (!halt_mode) begin
                        st_q <= PH_IDLE;
                    end else if (phase_end) begin
                        if (bit_q == total_q - 1'b1) begin
                            st_q    <= PH_IDLE;
                            done_q  <= 1'b1;
                            frame_q <= '0;
                        end else begin
                            st_q    <= PH_HIGH;
                            bit_q   <= bit_q + 1'b1;
                            frame_q <= frame_q << 1;
                        end
                    end
                end
                default: st_q <= PH_IDLE;
            endcase
        end
    end

    AST_SDI_HELD_LOW: assert property (@(posedge clk) disable iff (rst)
        (st_q == PH_LOW) |-> $stable(sdi_o)); // R3

    AST_HIGH_PHASE_MIN: assert property (@(posedge clk) disable iff (rst)
        (st_q == PH_LOW && $past(st_q) == PH_HIGH) |-> ($past(st_q, 2) == PH_HIGH)); // R3

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q); // R8

endmodule

// File: rtl/adc_rx_lane.sv
module adc_rx_lane
    import adc_sreg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             shift,
    input  logic             bit_in,
    output logic [REG_W-1:0] word
);
    always_ff @(posedge clk) begin
        if (rst || clear) word <= '0;
        else if (shift)   word <= {word[REG_W-2:0], bit_in};
    end

endmodule

// File: rtl/adc_sreg_master.sv
module adc_sreg_master
    import adc_sreg_pkg::*;
#(
    parameter int DIV_W     = 8,
    parameter int MIN_PHASE = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic                    rd_nwr,
    input  logic [1:0]              nbytes_m1,
    input  logic [3:0]              reg_addr,
    input  logic [31:0]             wr_data,
    input  logic                    cap_all,
    input  logic [1:0]              cap_sel,
    input  logic                    halt_mode,
    input  logic [DIV_W-1:0]        clk_div,
    input  logic                    seq_sclk,
    input  logic                    seq_sdi,
    input  logic [3:0]              sdo,
    output logic                    sclk,
    output logic                    sdi,
    output logic                    busy,
    output logic                    done,
    output logic                    mode_err,
    output logic [127:0]            rd_data
);
    req_t req;
    cap_t cap_q;
    logic accept;
    logic phase_end;
    logic sample_en;
    logic sclk_int;
    logic sdi_int;
    logic err_q;

    assign req      = '{rd: rd_nwr, nb_m1: nbytes_m1, addr: reg_addr};
    assign accept   = start && !busy && halt_mode;
    assign mode_err = err_q;
    assign sclk     = halt_mode ? sclk_int : seq_sclk;
    assign sdi      = halt_mode ? sdi_int  : seq_sdi;

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_q <= '0;
            err_q <= 1'b0;
        end else begin
            err_q <= start && !busy && !halt_mode;
            if (accept) cap_q <= '{all: cap_all, sel: cap_sel};
        end
    end

    adc_phase_timer #(.DIV_W(DIV_W), .MIN_PHASE(MIN_PHASE)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .load      (accept),
        .div_in    (clk_div),
        .run       (busy),
        .phase_end (phase_end)
    );

    adc_shift_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .req_in    (req),
        .wr_data   (wr_data),
        .halt_mode (halt_mode),
        .phase_end (phase_end),
        .busy      (busy),
        .sclk_o    (sclk_int),
        .sdi_o     (sdi_int),
        .sample_en (sample_en),
        .done      (done)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_lane
        logic lane_en;
        assign lane_en = sample_en && (cap_q.all || cap_q.sel == SEL_W'(g));
        adc_rx_lane u_lane (
            .clk    (clk),
            .rst    (rst),
            .clear  (accept && rd_nwr),
            .shift  (lane_en),
            .bit_in (sdo[g]),
            .word   (rd_data[g*REG_W +: REG_W])
        );
    end

    AST_IDLE_PINS_LOW: assert property (@(posedge clk) disable iff (rst)
        (halt_mode && !busy) |-> (!sclk && !sdi)); // R9

    AST_REFUSED_NO_BUSY: assert property (@(posedge clk) disable iff (rst)
        mode_err |-> !busy); // R7

    AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (mode_err && !$past(start)) |-> 1'b0 ); // R7

endmodule

// File: tb/adc_sreg_master_tb.sv
`timescale 1ns/1ps
module adc_sreg_master_tb;
    logic         clk = 0;
    logic         rst = 1;
    logic         start = 0, rd_nwr = 0, cap_all = 0, halt_mode = 1;
    logic [1:0]   nbytes_m1 = 0, cap_sel = 0;
    logic [3:0]   reg_addr = 0, sdo_r = 0;
    logic [31:0]  wr_data = 0;
    logic [7:0]   clk_div = 0;
    logic         seq_sclk = 0, seq_sdi = 0;
    logic         sclk, sdi, busy, done, mode_err;
    logic [127:0] rd_data;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    adc_sreg_master u_dut (
        .clk(clk), .rst(rst), .start(start), .rd_nwr(rd_nwr), .nbytes_m1(nbytes_m1),
        .reg_addr(reg_addr), .wr_data(wr_data), .cap_all(cap_all), .cap_sel(cap_sel),
        .halt_mode(halt_mode), .clk_div(clk_div), .seq_sclk(seq_sclk), .seq_sdi(seq_sdi),
        .sdo(sdo_r), .sclk(sclk), .sdi(sdi), .busy(busy), .done(done),
        .mode_err(mode_err), .rd_data(rd_data)
    );

    // Converter model: counts rising sclk, records sdi, drives data-out bits.
    logic [39:0]  cap_bits = 0;
    logic [31:0]  resp [4];
    int           mon_cnt = 0, base = 0, sdi_err = 0, cur_nb = 1;
    logic         cur_rd = 0, sclk_prev = 0, last_sdi = 0;

    always @(negedge clk) begin
        if (sclk && !sclk_prev) begin
            int idx;
            idx = mon_cnt - base;
            cap_bits = {cap_bits[38:0], sdi};
            last_sdi = sdi;
            if (cur_rd && idx >= 8 && idx < 8 * (cur_nb + 1))
                for (int k = 0; k < 4; k++) sdo_r[k] = resp[k][8 * cur_nb - 1 - (idx - 8)];
            mon_cnt = mon_cnt + 1;
        end
        if (!sclk && sclk_prev && sdi != last_sdi) sdi_err = sdi_err + 1;
        sclk_prev = sclk;
    end

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_txn(input logic rd, input int nb, input logic [3:0] addr, input logic [31:0] wd,
                           input logic all, input int sel, input int div, input bit glitch);
        int cnt, p, e0;
        logic [31:0] m;
        logic [127:0] prev, exp;
        logic [7:0] instr;
        @(negedge clk);
        clk_div = 8'(div); rd_nwr = rd; nbytes_m1 = 2'(nb - 1); reg_addr = addr;
        wr_data = wd; cap_all = all; cap_sel = 2'(sel);
        for (int k = 0; k < 4; k++)
            resp[k] = (32'h9E3779B9 * (k + 1)) ^ {wd[15:0], 8'(nb), 4'h0, addr};
        cur_rd = rd; cur_nb = nb; base = mon_cnt; e0 = sdi_err; prev = rd_data;
        start = 1;
        @(posedge clk);
        cnt = 0;
        forever begin
            @(negedge clk);
            if (cnt == 0) start = 0;
            if (glitch && cnt == 4) begin start = 1; rd_nwr = ~rd; reg_addr = ~addr; nbytes_m1 = ~nbytes_m1; end
            if (glitch && cnt == 5) start = 0;
            if (done || cnt > 6000) break;
            @(posedge clk);
            cnt++;
        end
        p = (div < 2) ? 2 : div;
        chk(cnt == 2 * p * 8 * (nb + 1), glitch ? "R6 cycle count with start while busy" : "R8 R3 cycle count",
            128'(cnt), 128'(2 * p * 8 * (nb + 1)));
        @(posedge clk); @(negedge clk);
        chk(done == 0, "R8 done one cycle", 128'(done), 128'(0));
        chk(mon_cnt - base == 8 * (nb + 1), "R2 serial clock count", 128'(mon_cnt - base), 128'(8 * (nb + 1)));
        instr = {rd, 2'(nb - 1), 1'b0, addr};
        chk(8'(cap_bits >> (8 * nb)) == instr, "R1 instruction byte", 128'(8'(cap_bits >> (8 * nb))), 128'(instr));
        m = (nb == 4) ? 32'hFFFF_FFFF : ((32'd1 << (8 * nb)) - 1);
        if (rd) chk((32'(cap_bits) & m) == 0, "R11 sdi low during read data", 128'(32'(cap_bits) & m), 128'(0));
        else    chk((32'(cap_bits) & m) == (wd & m), "R2 write data order", 128'(32'(cap_bits) & m), 128'(wd & m));
        chk(sdi_err == e0, "R3 sdi held through falling edge", 128'(sdi_err - e0), 128'(0));
        if (rd) begin
            for (int k = 0; k < 4; k++) exp[32 * k +: 32] = (all || sel == k) ? (resp[k] & m) : 32'h0;
            chk(rd_data == exp, all ? "R4 R5 read all lanes" : "R4 R5 read one lane", rd_data, exp);
        end else begin
            chk(rd_data == prev, "R8 write leaves read data", rd_data, prev);
        end
        chk(!sclk && !sdi && !busy, "R9 pins idle after transfer", {sclk, sdi, busy}, 128'(0));
    endtask

    initial begin
        #(10ns * 190000);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk) rst = 0;
        @(negedge clk);
        chk(!sclk && !sdi && !busy && !done && !mode_err, "R9 reset pins", {sclk, sdi, busy, done, mode_err}, 128'(0));
        chk(rd_data == 0, "R9 reset read data", rd_data, 128'(0));

        // R10: pins follow the sequencer outside halt mode.
        halt_mode = 0; seq_sclk = 1; seq_sdi = 1; #1;
        chk(sclk && sdi, "R10 sequencer owns pins", {sclk, sdi}, 128'(3));
        seq_sdi = 0; #1;
        chk(sclk && !sdi, "R10 sequencer sdi", {sclk, sdi}, 128'(2));
        seq_sclk = 0;

        // R7: start refused in run mode.
        @(negedge clk) start = 1;
        @(negedge clk) start = 0;
        chk(mode_err && !busy, "R7 refused start flags error", {mode_err, busy}, 128'(2));
        @(negedge clk);
        chk(!mode_err && !busy, "R7 error one cycle, no transfer", {mode_err, busy}, 128'(0));
        halt_mode = 1;

        // Sweep: phase lengths, byte counts, addresses, directions, lane modes.
        for (int d = 0; d < 2; d++) begin
            for (int nb = 1; nb <= 4; nb++) begin
                for (int a = 0; a < 4; a++) begin
                    logic [31:0] wd;
                    wd = 32'hC3A5_1E87 ^ (32'h0101_0101 * (a + 4 * nb + d));
                    run_txn(0, nb, 4'(4 * a), wd, 0, 0, d * 3, (a == 1));
                    for (int md = 0; md < 5; md++)
                        run_txn(1, nb, 4'(4 * a), wd + 32'(md), md == 4, md % 4, d * 3, (md == 2));
                end
            end
        end

        // R10: dropping halt mode aborts a transfer, no done.
        begin
            bit saw_done;
            saw_done = 0;
            @(negedge clk);
            rd_nwr = 1; nbytes_m1 = 2; clk_div = 2; start = 1;
            @(negedge clk) start = 0;
            repeat (10) @(negedge clk);
            halt_mode = 0;
            repeat (300) begin
                @(negedge clk);
                if (done) saw_done = 1;
            end
            chk(!saw_done && !busy, "R10 abort without done", {saw_done, busy}, 128'(0));
            halt_mode = 1;
            @(negedge clk);
            chk(!sclk && !sdi, "R9 idle pins after abort", {sclk, sdi}, 128'(0));
        end
        run_txn(1, 3, 4'h8, 32'h1234_5678, 1, 0, 4, 0);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule